// File: doc/BRIEF.md
# Oversampled Start-Bit Detector

This block sits at the front of a serial receiver. It watches the receive line, which it first passes through its own synchronizer. It decides whether a falling edge on that line is the leading edge of a real start bit or only a glitch. All timing is counted in ticks of an oversampling enable that runs at sixteen times the bit rate. The detector gives the sample right after the edge position 1. It then votes on two groups of three later samples inside the start bit. The early group is at positions 3, 5 and 7. The late group is at positions 8, 9 and 10.

Each group either rejects the candidate, passes with noise, or passes clean. A rejection at either group sends the detector back to idle with no output. It then waits for a new falling edge. When both groups pass, a one-clock start pulse is issued right after the tick of position 10, so that data-bit sampling can take its phase from that point. A noise qualifier accompanies the pulse when one group was not unanimous. The receive enable gates the whole detector.

Top module: `start_bit_detector`

## Requirements
- R1: After reset, start_valid, start_noisy and busy are all 0.
- R2: While idle and enabled, a tick that samples 0 on the synchronized line, when the previous tick sampled 1, starts an evaluation. That tick is position 1, and busy is 1 from the clock after that tick.
- R3: If all six voted samples (positions 3, 5, 7, 8, 9, 10) are 0, start_valid is 1 and start_noisy is 0 in the single clock after the tick of position 10. Samples at unvoted positions (2, 4, 6) have no effect on the result.
- R4: If both groups have at least two zeros and one group has exactly two, start_valid and start_noisy are both 1 in the clock after the tick of position 10.
- R5: If the group at positions 3, 5, 7 has fewer than two zeros, busy is 0 from the clock after the tick of position 7, and no start_valid is produced.
- R6: If the group at positions 8, 9, 10 has fewer than two zeros, busy is 0 from the clock after the tick of position 10, and no start_valid is produced.
- R7: While rx_en is 0, the detector is idle. busy and start_valid are 0 in the following clock, and a validation that was due at that tick is suppressed.
- R8: A line that is already low when the detector is enabled starts no evaluation, because a falling edge seen on a tick is required.
- R9: start_valid is never high for two clocks in a row, and start_noisy is only 1 together with start_valid.
- R10: The position counter advances only on ticks. Without ticks, busy holds and no start_valid appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rx_en | input | 1 | Receive enable; 0 forces idle |
| rx_line | input | 1 | Asynchronous serial receive line |
| start_valid | output | 1 | One-clock pulse: start bit accepted |
| start_noisy | output | 1 | Set with start_valid when a vote was 2 of 3 |
| busy | output | 1 | An edge is being evaluated |

## Verification
The bench uses the default oversampling ratio of 16 and a two-stage synchronizer. With these values every voted position, 3 through 10, fits in the counter. The bench sets up each sample and lets it settle through the synchronizer before it pulses the tick. This brings each voting outcome within reach: clean, noisy in the early group, noisy in the late group, and rejected at either group. It also reaches the enable dropping exactly on the final tick and long gaps between ticks.

// File: rtl/sbd_pkg.sv
`timescale 1ns/1ps
package sbd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EARLY = 2'd1,
        ST_LATE  = 2'd2
    } sbd_state_e;

    typedef enum logic [1:0] {
        VOTE_REJECT = 2'd0,
        VOTE_NOISY  = 2'd1,
        VOTE_CLEAN  = 2'd2
    } sbd_vote_e;

    localparam int EARLY_P0 = 3;
    localparam int EARLY_P1 = 5;
    localparam int EARLY_P2 = 7;
    localparam int LATE_P0  = 8;
    localparam int LATE_P1  = 9;
    localparam int LATE_P2  = 10;
endpackage

// File: rtl/sbd_sync.sv
`timescale 1ns/1ps
module sbd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= 1'b1;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 1'b1;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sbd_vote.sv
`timescale 1ns/1ps
module sbd_vote
    import sbd_pkg::*;
(
    input  logic [2:0] zeros,
    output sbd_vote_e  verdict
);
    logic [1:0] n_zero;

    always_comb begin
        n_zero = 2'($countones(zeros));
        if (n_zero == 2'd3)      verdict = VOTE_CLEAN;
        else if (n_zero == 2'd2) verdict = VOTE_NOISY;
        else                     verdict = VOTE_REJECT;
    end
endmodule

// File: rtl/start_bit_detector.sv
`timescale 1ns/1ps
module start_bit_detector
    import sbd_pkg::*;
#(
    parameter int OSR_RATE    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rx_en,
    input  logic rx_line,
    output logic start_valid,
    output logic start_noisy,
    output logic busy
);
    localparam int CNT_W = $clog2(OSR_RATE);

    typedef struct packed {
        sbd_state_e       st;
        logic [CNT_W-1:0] pos;
        logic             prev;
        logic [1:0]       early_z;
        logic [1:0]       late_z;
        logic             early_noisy;
        logic             ok;
        logic             noisy;
    } sbd_regs_t;

    sbd_regs_t r_q, r_d;

    logic rx_s;
    logic smp_zero;
    logic [CNT_W-1:0] pos_next;
    sbd_vote_e early_v, late_v;

    sbd_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    assign smp_zero = ~rx_s;
    assign pos_next = r_q.pos + CNT_W'(1);

    sbd_vote i_vote_early (.zeros({smp_zero, r_q.early_z}), .verdict(early_v));
    sbd_vote i_vote_late  (.zeros({smp_zero, r_q.late_z}),  .verdict(late_v));

    always_comb begin
        r_d       = r_q;
        r_d.ok    = 1'b0;
        r_d.noisy = 1'b0;
        if (os_tick) r_d.prev = rx_s;
        unique case (r_q.st)
            ST_IDLE: begin
                if (os_tick && r_q.prev && !rx_s) begin
                    r_d.st          = ST_EARLY;
                    r_d.pos         = CNT_W'(1);
                    r_d.early_z     = 2'b00;
                    r_d.late_z      = 2'b00;
                    r_d.early_noisy = 1'b0;
                end
            end
            ST_EARLY: begin
                if (os_tick) begin
                    r_d.pos = pos_next;
                    if (pos_next == CNT_W'(EARLY_P0)) r_d.early_z[0] = smp_zero;
                    if (pos_next == CNT_W'(EARLY_P1)) r_d.early_z[1] = smp_zero;
                    if (pos_next == CNT_W'(EARLY_P2)) begin
                        if (early_v == VOTE_REJECT) begin
                            r_d.st = ST_IDLE;
                        end else begin
                            r_d.st          = ST_LATE;
                            r_d.early_noisy = (early_v == VOTE_NOISY);
                        end
                    end
                end
            end
            ST_LATE: begin
                if (os_tick) begin
                    r_d.pos = pos_next;
                    if (pos_next == CNT_W'(LATE_P0)) r_d.late_z[0] = smp_zero;
                    if (pos_next == CNT_W'(LATE_P1)) r_d.late_z[1] = smp_zero;
                    if (pos_next == CNT_W'(LATE_P2)) begin
                        r_d.st = ST_IDLE;
                        if (late_v != VOTE_REJECT) begin
                            r_d.ok    = 1'b1;
                            r_d.noisy = r_q.early_noisy || (late_v == VOTE_NOISY);
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (!rx_en) begin
            r_d.st    = ST_IDLE;
            r_d.ok    = 1'b0;
            r_d.noisy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q             <= '0;
            r_q.st          <= ST_IDLE;
            r_q.prev        <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_valid = r_q.ok;
    assign start_noisy = r_q.noisy;
    assign busy        = (r_q.st != ST_IDLE);

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> !start_valid);
    assert_noise_qualifies_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_noisy |-> start_valid);
    assert_disable_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!busy && !start_valid));
    assert_no_tick_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !os_tick |=> !start_valid);
    assert_no_tick_holds_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!os_tick && rx_en && busy) |=> busy);
    assert_pulse_leaves_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> !busy);
    assert_start_needs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(os_tick && rx_en));
endmodule

// File: tb/test_start_bit_detector.sv
`timescale 1ns/1ps
module test_start_bit_detector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rx_en = 1'b0;
    logic rx_line = 1'b1;
    logic start_valid, start_noisy, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    start_bit_detector #(.OSR_RATE(16), .SYNC_STAGES(2)) i_start_bit_detector (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
        .rx_line(rx_line), .start_valid(start_valid),
        .start_noisy(start_noisy), .busy(busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one sample, let it settle, tick once; return outputs one clock after the tick.
    task automatic step(input logic v, input logic en_at_tick,
                        output logic ok, output logic nz, output logic bz);
        @(negedge clk) rx_line = v;
        repeat (3) @(negedge clk);
        rx_en = en_at_tick;
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
        rx_en = 1'b1;
        ok = start_valid; nz = start_noisy; bz = busy;
    endtask

    task automatic idle_steps(input int n, input string req);
        logic ok, nz, bz;
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b1, ok, nz, bz);
            chk(req, "idle start_valid", ok, 0);
            chk(req, "idle busy", bz, 0);
        end
    endtask

    // p[i] is the sample at position i+1; p[0] must be 0 (the edge).
    task automatic run_frame(input logic [9:0] p, input string req);
        logic ok, nz, bz;
        int za, zb, last;
        bit exp_ok, exp_nz;
        za = (!p[2]) + (!p[4]) + (!p[6]);
        zb = (!p[7]) + (!p[8]) + (!p[9]);
        last = (za < 2) ? 7 : 10;
        exp_ok = (za >= 2) && (zb >= 2);
        exp_nz = exp_ok && (za == 2 || zb == 2);
        idle_steps(2, req);
        for (int k = 1; k <= last; k++) begin
            step(p[k-1], 1'b1, ok, nz, bz);
            if (k == 1) chk("R2", "busy after edge", bz, 1);
            else if (k < last) chk(req, "busy mid-frame", bz, 1);
            else chk(req, "busy at end", bz, 0);
            chk(req, "start_valid", ok, (k == last) ? int'(exp_ok) : 0);
            chk(req, "start_noisy", nz, (k == last) ? int'(exp_nz) : 0);
        end
        @(negedge clk);
        chk("R9", "pulse width", start_valid, 0);
        idle_steps(1, req);
    endtask

    task automatic t_reset();
        chk("R1", "reset start_valid", start_valid, 0);
        chk("R1", "reset start_noisy", start_noisy, 0);
        chk("R1", "reset busy", busy, 0);
    endtask

    task automatic t_disable_mid();
        logic ok, nz, bz;
        idle_steps(2, "R7");
        for (int k = 1; k <= 5; k++) step(1'b0, 1'b1, ok, nz, bz);
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk);
        chk("R7", "busy after disable", busy, 0);
        rx_en = 1'b1;
        for (int k = 6; k <= 10; k++) begin
            step(1'b0, 1'b1, ok, nz, bz);
            chk("R7", "no pulse after disable", ok, 0);
            chk("R7", "stays idle", bz, 0);
        end
    endtask

    task automatic t_disable_final();
        logic ok, nz, bz;
        idle_steps(2, "R7");
        for (int k = 1; k <= 9; k++) step(1'b0, 1'b1, ok, nz, bz);
        chk("R7", "busy before final", bz, 1);
        step(1'b0, 1'b0, ok, nz, bz);
        chk("R7", "suppressed pulse", ok, 0);
        chk("R7", "idle after suppressed", bz, 0);
    endtask

    task automatic t_low_at_enable();
        logic ok, nz, bz;
        idle_steps(1, "R8");
        @(negedge clk) rx_en = 1'b0;
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        os_tick = 1'b1;
        @(negedge clk) os_tick = 1'b0;
        rx_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            step(1'b0, 1'b1, ok, nz, bz);
            chk("R8", "no start on held low", bz, 0);
            chk("R8", "no pulse on held low", ok, 0);
        end
        idle_steps(1, "R8");
    endtask

    task automatic t_tick_gap();
        logic ok, nz, bz;
        idle_steps(2, "R10");
        for (int k = 1; k <= 4; k++) step(1'b0, 1'b1, ok, nz, bz);
        for (int c = 0; c < 50; c++) begin
            @(negedge clk);
            rx_line = c[0];
            if (c % 10 == 9) begin
                chk("R10", "busy held without ticks", busy, 1);
                chk("R10", "no pulse without ticks", start_valid, 0);
            end
        end
        for (int k = 5; k <= 9; k++) begin
            step(1'b0, 1'b1, ok, nz, bz);
            chk("R10", "no early pulse", ok, 0);
        end
        step(1'b0, 1'b1, ok, nz, bz);
        chk("R10", "pulse at position 10", ok, 1);
        chk("R10", "clean after gap", nz, 0);
        idle_steps(1, "R10");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        rx_en = 1'b1;
        run_frame(10'b0000000000, "R3");
        run_frame(10'b0000101010, "R3");
        run_frame(10'b0000000100, "R4");
        run_frame(10'b0100000000, "R4");
        run_frame(10'b0000010000, "R4");
        run_frame(10'b0001010000, "R5");
        run_frame(10'b0001000100, "R5");
        run_frame(10'b1010000000, "R6");
        run_frame(10'b1110000000, "R6");
        run_frame(10'b0100000100, "R4");
        t_disable_mid();
        t_disable_final();
        t_low_at_enable();
        t_tick_gap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule